// File: doc/BRIEF.md
# ECC Error Interrupt Notification Controller

This block decides how a memory controller tells the rest of the system about ECC errors. The error logging logic supplies two one-cycle strobes, one for a logged single-bit (corrected) error and one for a logged multiple-bit (non-correctable) error. A two-bit access tag comes with each strobe and says whether the failing access was a processor read, a processor write or a background scrub.

A small register, written through a single-cycle write port and always readable, holds three enable bits and a sticky interrupt bit. The sticky bit drives a level-sensitive internal error interrupt. A separate active-low machine-check output gives a one-cycle pulse for non-correctable errors that a processor access hits. The block never terminates a bus transfer with an error. Notification goes only through the interrupt level and the machine-check pulse.

The asynchronous active-low reset takes effect at once. Its release is synchronised inside the block.

Top module: `ecc_err_notify`

## Requirements
- R1: While reset is asserted, and after its synchronised release, all enable bits and the sticky bit read zero, `err_irq` is low and `mchk_n` is high.
- R2: A `sbe_log` strobe with the single-bit enable (register bit 0) set makes the sticky bit (register bit 3) read one from the next cycle. With that enable clear, the strobe has no effect.
- R3: A `mbe_log` strobe with the non-correctable enable (register bit 1) set makes the sticky bit read one from the next cycle, for every access tag including scrub. With that enable clear, the strobe does not set the bit.
- R4: Once set, the sticky bit stays set until reset or a register write with bit 3 equal to one. A write with bit 3 equal to zero leaves it unchanged, and further error events keep it set.
- R5: If a write with bit 3 equal to one coincides with an enabled error event, the sticky bit stays set.
- R6: `err_irq` equals the sticky bit in every cycle. It rises and falls in the same cycle as the bit changes.
- R7: A `mbe_log` strobe with the machine-check enable (register bit 2) set and the access tag equal to 2'b00 (processor read) or 2'b01 (processor write) drives `mchk_n` low for exactly the next cycle. Otherwise `mchk_n` idles high.
- R8: With the machine-check enable clear, `mchk_n` never goes low.
- R9: A `mbe_log` strobe with the access tag 2'b10 (scrub) or 2'b11 never drives `mchk_n` low, whatever the enables.
- R10: Register bits 0 to 2 are ordinary read/write bits. A written value is read back from the next cycle. An event in the same cycle as the write uses the previous enable values.
- R11: A single-bit error strobe never drives `mchk_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sbe_log | input | 1 | One-cycle strobe: single-bit error logged |
| mbe_log | input | 1 | One-cycle strobe: non-correctable error logged |
| acc_kind | input | 2 | Access tag: 00 read, 01 write, 10 scrub, 11 reserved |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 4 | Write data: bit0 single enable, bit1 non-correctable enable, bit2 machine-check enable, bit3 write-one-to-clear sticky |
| cfg_rdata | output | 4 | Register read value in the same bit layout, bit3 the sticky bit |
| err_irq | output | 1 | Level-sensitive internal error interrupt |
| mchk_n | output | 1 | Active-low one-cycle machine-check pulse |

## Verification
A sticky bit that is wrong shows up on `err_irq` and on `cfg_rdata[3]` in the first cycle after the event or write that should have changed it. A corrupted enable shows up on `cfg_rdata` one cycle after the write. Its effect on the error paths shows on the next strobe. A fault in the machine-check path gives a missing, stretched or spurious low cycle on `mchk_n` in the cycle right after the strobe, so comparing every clock catches it without delay. The stimulus includes scrub and reserved tags, writes that clear the bit during an event, and writes of zero. These are the cases where a wrong gate leaves the outputs still looking plausible.

// File: rtl/ecc_notify_pkg.sv
package ecc_notify_pkg;
  localparam int unsigned KIND_W = 2;
  localparam int unsigned REG_W  = 4;

  localparam int unsigned BIT_SBE_EN  = 0;
  localparam int unsigned BIT_MBE_EN  = 1;
  localparam int unsigned BIT_MCHK_EN = 2;
  localparam int unsigned BIT_STICKY  = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_CPU_RD = 2'b00,
    KIND_CPU_WR = 2'b01,
    KIND_SCRUB  = 2'b10,
    KIND_RSVD   = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic mchk_en;
    logic mbe_en;
    logic sbe_en;
  } enables_t;

  function automatic logic is_cpu_access(input logic [KIND_W-1:0] k);
    return (k == KIND_CPU_RD) || (k == KIND_CPU_WR);
  endfunction
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ecc_cfg_regs.sv
module ecc_cfg_regs
  import ecc_notify_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output enables_t         en
);
  enables_t en_q;
  enables_t en_d;
  logic     en_load;

  always_comb begin
    en_load    = cfg_we;
    en_d.sbe_en  = cfg_wdata[BIT_SBE_EN];
    en_d.mbe_en  = cfg_wdata[BIT_MBE_EN];
    en_d.mchk_en = cfg_wdata[BIT_MCHK_EN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_load) en_q <= en_d;
  end

  assign en = en_q;

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (en_q == $past(en_d)));
  assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(en_q));
endmodule

// File: rtl/ecc_irq_sticky.sv
module ecc_irq_sticky
  import ecc_notify_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  enables_t en,
  input  logic     sbe_log,
  input  logic     mbe_log,
  input  logic     clr_req,
  output logic     sticky
);
  logic sticky_q;
  logic sticky_d;
  logic set_req;
  logic upd;

  always_comb begin
    set_req  = (sbe_log && en.sbe_en) || (mbe_log && en.mbe_en);
    upd      = set_req || clr_req;
    sticky_d = set_req ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sticky_q <= 1'b0;
    else if (upd) sticky_q <= sticky_d;
  end

  assign sticky = sticky_q;

  assert_sbe_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_log && en.sbe_en) |=> sticky_q);
  assert_mbe_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mbe_log && en.mbe_en) |=> sticky_q);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !clr_req) |=> sticky_q);
  assert_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_q) |-> $past((sbe_log && en.sbe_en) || (mbe_log && en.mbe_en)));
endmodule

// File: rtl/ecc_mchk_pulse.sv
module ecc_mchk_pulse
  import ecc_notify_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  enables_t          en,
  input  logic              mbe_log,
  input  logic [KIND_W-1:0] acc_kind,
  output logic              mchk_n
);
  logic fire_q;
  logic fire_d;

  always_comb begin
    fire_d = mbe_log && en.mchk_en && is_cpu_access(acc_kind);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= fire_d;
  end

  assign mchk_n = ~fire_q;

  assert_scrub_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mbe_log && !is_cpu_access(acc_kind)) |=> mchk_n);
  assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en.mchk_en |=> mchk_n);
  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mchk_n |-> $past(mbe_log && is_cpu_access(acc_kind)));
  assert_sbe_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mbe_log) |=> mchk_n);
endmodule

// File: rtl/ecc_err_notify.sv
module ecc_err_notify
  import ecc_notify_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sbe_log,
  input  logic             mbe_log,
  input  logic [1:0]       acc_kind,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_wdata,
  output logic [3:0]       cfg_rdata,
  output logic             err_irq,
  output logic             mchk_n
);
  logic     rst_i_n;
  enables_t en;
  logic     sticky;
  logic     clr_req;

  ecc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  ecc_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .en        (en)
  );

  always_comb begin
    clr_req = cfg_we && cfg_wdata[BIT_STICKY];
  end

  ecc_irq_sticky u_sticky (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .en      (en),
    .sbe_log (sbe_log),
    .mbe_log (mbe_log),
    .clr_req (clr_req),
    .sticky  (sticky)
  );

  ecc_mchk_pulse u_mchk (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .en       (en),
    .mbe_log  (mbe_log),
    .acc_kind (acc_kind),
    .mchk_n   (mchk_n)
  );

  always_comb begin
    cfg_rdata              = '0;
    cfg_rdata[BIT_SBE_EN]  = en.sbe_en;
    cfg_rdata[BIT_MBE_EN]  = en.mbe_en;
    cfg_rdata[BIT_MCHK_EN] = en.mchk_en;
    cfg_rdata[BIT_STICKY]  = sticky;
  end

  assign err_irq = sticky;

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(err_irq) |-> $past(cfg_we && cfg_wdata[BIT_STICKY]));
  assert_setwins_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (clr_req && ((sbe_log && cfg_rdata[BIT_SBE_EN]) || (mbe_log && cfg_rdata[BIT_MBE_EN])))
      |=> err_irq);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (mchk_n && !err_irq));
endmodule

// File: tb/ecc_err_notify_bench.sv
`timescale 1ns/1ps
module ecc_err_notify_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sbe_log, mbe_log, cfg_we;
  logic [1:0] acc_kind;
  logic [3:0] cfg_wdata;
  logic [3:0] cfg_rdata;
  logic       err_irq, mchk_n;

  int checks = 0;
  int errors = 0;

  bit m_sbe_en, m_mbe_en, m_mchk_en, m_sticky, m_fire;

  always #2.5 clk = ~clk;

  ecc_err_notify u_ecc_err_notify (
    .clk(clk), .rst_n(rst_n), .sbe_log(sbe_log), .mbe_log(mbe_log),
    .acc_kind(acc_kind), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .err_irq(err_irq), .mchk_n(mchk_n)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {rdata,irq,mchk_n} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(input string req);
    check(req, {cfg_rdata, err_irq, mchk_n},
          {m_sticky, m_mchk_en, m_mbe_en, m_sbe_en, m_sticky, ~m_fire});
  endtask

  task automatic step(input bit s, input bit m, input logic [1:0] k,
                      input bit we, input logic [3:0] wd, input string req);
    bit setv, clrv;
    sbe_log = s; mbe_log = m; acc_kind = k; cfg_we = we; cfg_wdata = wd;
    @(posedge clk);
    setv = (s && m_sbe_en) || (m && m_mbe_en);
    clrv = we && wd[3];
    m_fire = m && m_mchk_en && (k == 2'b00 || k == 2'b01);
    m_sticky = setv || (m_sticky && !clrv);
    if (we) begin
      m_sbe_en = wd[0]; m_mbe_en = wd[1]; m_mchk_en = wd[2];
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle(input string req);
    step(0, 0, 2'b00, 0, 4'h0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sbe_log = 0; mbe_log = 0; acc_kind = 2'b00; cfg_we = 0; cfg_wdata = 0;
    m_sbe_en = 0; m_mbe_en = 0; m_mchk_en = 0; m_sticky = 0; m_fire = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    // events during reset must not matter
    sbe_log = 1; mbe_log = 1; cfg_we = 1; cfg_wdata = 4'h7;
    @(negedge clk);
    compare("R1");
    sbe_log = 0; mbe_log = 0; cfg_we = 0; cfg_wdata = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) idle("R1");

    // disabled events do nothing
    step(1, 0, 2'b00, 0, 4'h0, "R2");
    step(0, 1, 2'b00, 0, 4'h0, "R3");
    step(0, 1, 2'b01, 0, 4'h0, "R8");

    // enable programming and readback
    step(0, 0, 2'b00, 1, 4'h5, "R10");
    step(0, 0, 2'b00, 1, 4'h2, "R10");
    step(0, 0, 2'b00, 1, 4'h0, "R10");

    // single-bit path
    step(0, 0, 2'b00, 1, 4'h1, "R10");
    step(1, 0, 2'b10, 0, 4'h0, "R2");
    idle("R6");
    step(0, 0, 2'b00, 1, 4'h1, "R4");
    step(1, 0, 2'b00, 0, 4'h0, "R4");
    step(0, 0, 2'b00, 1, 4'h9, "R4");
    idle("R6");

    // set wins over clear
    step(1, 0, 2'b00, 1, 4'h9, "R5");
    idle("R5");
    step(0, 0, 2'b00, 1, 4'h8, "R4");

    // enable written in same cycle as event uses old value
    step(0, 1, 2'b00, 1, 4'h2, "R10");
    step(0, 1, 2'b10, 0, 4'h0, "R3");
    step(0, 0, 2'b00, 1, 4'hA, "R4");
    step(1, 0, 2'b00, 0, 4'h0, "R2");

    // machine check paths
    step(0, 0, 2'b00, 1, 4'h4, "R10");
    step(0, 1, 2'b00, 0, 4'h0, "R7");
    idle("R7");
    step(0, 1, 2'b01, 0, 4'h0, "R7");
    step(0, 1, 2'b01, 0, 4'h0, "R7");
    idle("R7");
    step(0, 1, 2'b10, 0, 4'h0, "R9");
    step(0, 1, 2'b11, 0, 4'h0, "R9");
    step(1, 0, 2'b00, 0, 4'h0, "R11");
    idle("R9");

    // all enabled: scrub sets sticky but no pulse
    step(0, 0, 2'b00, 1, 4'h7, "R10");
    step(0, 1, 2'b10, 0, 4'h0, "R9");
    step(0, 1, 2'b00, 1, 4'hF, "R5");
    step(1, 1, 2'b01, 0, 4'h0, "R7");
    step(0, 0, 2'b00, 1, 4'h3, "R8");
    step(0, 1, 2'b00, 0, 4'h0, "R8");
    step(0, 0, 2'b00, 1, 4'h8, "R4");
    idle("R6");

    // asynchronous reset mid-run
    step(0, 0, 2'b00, 1, 4'h7, "R10");
    step(1, 0, 2'b00, 0, 4'h0, "R2");
    #1 rst_n = 1'b0;
    m_sbe_en = 0; m_mbe_en = 0; m_mchk_en = 0; m_sticky = 0; m_fire = 0;
    #1 compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) idle("R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule